// File: doc/BRIEF.md
# Manchester Serial Bus Loopback Self-Test Controller

This block runs a self test of a dual-redundant Manchester II serial bus interface. On a start request it builds one fixed 16-bit test word, wraps it in a chosen sync pattern and an odd parity bit, and serialises it. The serial stream returns to a built-in receiver along one of two paths. The first is an internal digital path that leaves both buses silent. The second is an analog path that drives the selected bus pins and listens on that bus's receive pins.

The receiver aligns to the start of incoming activity and samples every half-bit cell in its middle. It then checks the sync pattern, the Manchester pairing of each cell, odd parity and the data value. The result is latched as pass or fail, together with a five-bit cause code. A test is only accepted while the external test-enable input is high. The start flag stays set until the result is known.

Top module: `lbt_top`

## Requirements
- R1: With the analog bit (write bit 3) at 0, the loop is internal: both bus transmit enables and transmit lines stay 0, and the receive pins of both buses have no effect on the result.
- R2: With the analog bit at 1, the word is driven on the selected bus (`bus_x_txen` high, `bus_x_tx` carrying the level) and is received from that bus's `bus_x_rx`/`bus_x_rxact` pins.
- R3: Bus-select (write bit 1) at 0 uses bus A and at 1 uses bus B. The other bus's transmit pins stay 0.
- R4: Sync-select (write bit 2) at 1 sends a command sync: three half-bits high, then three low. At 0 it sends the inverse (data sync).
- R5: The word lasts 40 half-bit cells of HALF_CLKS clocks each. After the sync come the 16 bits of 0xA5C3, MSB first, with 1 sent as high-then-low and 0 as low-then-high. Last comes an odd parity bit over the 16 data bits.
- R6: A write with bit 0 set starts a test only if `test_en` is high. The start flag (`ctl_o[0]`) clears itself at completion. Writes made while a test runs change nothing.
- R7: After reset all outputs are 0. Starting a test clears pass, fail and the cause code in the same edge.
- R8: Failure causes are reported in `fail_why_o`: bit 0 Manchester error (a cell with equal halves), bit 1 parity error, bit 2 sync error (the first six half-bits differ from the selected sync), bit 3 data mismatch. Pass is set only when none applies, and pass and fail are never both set.
- R9: If no receive activity starts within 32 bit times after the word ends (104·HALF_CLKS clocks after the start edge), the test ends with fail and `fail_why_o` = 5'b10000.
- R10: When a word is received, the result appears 40·HALF_CLKS+2 clock edges after the edge that accepted the start. Transmission occupies edges 1 to 40·HALF_CLKS after it.
- R11: `ctl_o` reads back {analog, sync-select, bus-select, start flag} in bits 3 down to 0. The configuration bits follow any write made while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| test_en | input | 1 | External test enable, gates start |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 4 | {analog, sync_cmd, bus_b, start} |
| ctl_o | output | 4 | Control readback, bit 0 is the start/busy flag |
| pass_o | output | 1 | Test passed |
| fail_o | output | 1 | Test failed |
| fail_why_o | output | 5 | {timeout, data, sync, parity, manchester} |
| bus_a_tx | output | 1 | Bus A transmit level |
| bus_a_txen | output | 1 | Bus A transmitter enable |
| bus_a_rx | input | 1 | Bus A received level |
| bus_a_rxact | input | 1 | Bus A receive activity |
| bus_b_tx | output | 1 | Bus B transmit level |
| bus_b_txen | output | 1 | Bus B transmitter enable |
| bus_b_rx | input | 1 | Bus B received level |
| bus_b_rxact | input | 1 | Bus B receive activity |

## Verification
The assertions assume that `reg_wdata` is meaningful only while `reg_wr` is high, and that in analog mode the receive activity line rises no earlier than the transmitter enable of the selected bus and stays high for a whole word. The bench keeps within this by returning each transmitted half-bit half a clock later on the same bus, with corruption only in the level. It suppresses activity altogether for the timeout case. In digital mode it deliberately toggles the receive pins to show they are ignored.

// File: rtl/lbt_pkg.sv
package lbt_pkg;
  localparam int WORD_HALVES = 40;
  localparam int SYNC_HALVES = 6;
  localparam int NCELLS      = 17;

  // cause bit positions in the latched code
  localparam int E_MANCH = 0;
  localparam int E_PAR   = 1;
  localparam int E_SYNC  = 2;
  localparam int E_DATA  = 3;
  localparam int E_TMO   = 4;

  typedef struct packed {
    logic analog;
    logic sync_cmd;
    logic bus_b;
  } lbt_cfg_t;

  // full half-bit image of a word, bit 39 goes out first
  function automatic logic [WORD_HALVES-1:0] lbt_halves(input logic [15:0] w, input logic cmd);
    logic [WORD_HALVES-1:0] h;
    logic b;
    h[39:34] = cmd ? 6'b111000 : 6'b000111;
    for (int c = 0; c < NCELLS; c++) begin
      b = (c < 16) ? w[15-c] : ~(^w);
      h[33-2*c] = b;
      h[32-2*c] = ~b;
    end
    return h;
  endfunction

  // receive checks: {data, sync, parity, manch}
  function automatic logic [3:0] lbt_check(input logic [WORD_HALVES-1:0] h, input logic cmd,
                                           input logic [15:0] pat);
    logic [NCELLS-1:0] v;
    logic manch;
    manch = 1'b0;
    v = '0;
    for (int c = 0; c < NCELLS; c++) begin
      v = {v[NCELLS-2:0], h[33-2*c]};
      if (h[33-2*c] == h[32-2*c]) manch = 1'b1;
    end
    return {v[16:1] != pat,
            h[39:34] != (cmd ? 6'b111000 : 6'b000111),
            ~(^v),
            manch};
  endfunction
endpackage

// File: rtl/lbt_enc.sv
module lbt_enc
  import lbt_pkg::*;
#(
  parameter int HALF_CLKS = 4,
  parameter logic [15:0] WORD = 16'hA5C3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic cmd,
  output logic line,
  output logic act
);
  localparam int SW = (HALF_CLKS > 2) ? $clog2(HALF_CLKS) : 1;
  localparam int HW = $clog2(WORD_HALVES);
  localparam logic [SW-1:0] SUB_LAST  = SW'(HALF_CLKS - 1);
  localparam logic [HW-1:0] HALF_LAST = HW'(WORD_HALVES - 1);

  logic [WORD_HALVES-1:0] sh;
  logic [SW-1:0] sub;
  logic [HW-1:0] half;
  logic cell_end;

  assign cell_end = act && (sub == SUB_LAST);
  assign line = sh[WORD_HALVES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh <= '0; sub <= '0; half <= '0; act <= 1'b0;
    end else if (go) begin
      sh <= lbt_halves(WORD, cmd);
      sub <= '0; half <= '0; act <= 1'b1;
    end else if (cell_end) begin
      sub <= '0;
      sh <= {sh[WORD_HALVES-2:0], 1'b0};
      if (half == HALF_LAST) act <= 1'b0;
      else half <= half + 1'b1;
    end else if (act) begin
      sub <= sub + 1'b1;
    end
  end

  // R5: a word always spans the full set of half-bit cells
  p_word_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act) |-> $past(half) == HALF_LAST);
endmodule

// File: rtl/lbt_dec.sv
module lbt_dec
  import lbt_pkg::*;
#(
  parameter int HALF_CLKS = 4,
  parameter logic [15:0] WORD = 16'hA5C3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic cmd,
  input  logic rx,
  input  logic rxact,
  output logic seen,
  output logic done,
  output logic [3:0] errs
);
  localparam int SW = (HALF_CLKS > 2) ? $clog2(HALF_CLKS) : 1;
  localparam int HW = $clog2(WORD_HALVES);
  localparam logic [SW-1:0] SUB_LAST  = SW'(HALF_CLKS - 1);
  localparam logic [SW-1:0] SUB_SMP   = SW'(HALF_CLKS / 2);
  localparam logic [HW-1:0] HALF_LAST = HW'(WORD_HALVES - 1);

  logic armed, cap;
  logic [SW-1:0] sub;
  logic [HW-1:0] half;
  logic [WORD_HALVES-1:0] sh;
  logic detect;

  assign detect = armed && !cap && rxact;
  assign seen = cap || done;
  assign errs = lbt_check(sh, cmd, WORD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0; cap <= 1'b0; done <= 1'b0;
      sub <= '0; half <= '0; sh <= '0;
    end else begin
      done <= 1'b0;
      if (arm) begin
        armed <= 1'b1; cap <= 1'b0;
      end else if (detect) begin
        armed <= 1'b0; cap <= 1'b1;
        sub <= SW'(1); half <= '0;
      end else if (cap) begin
        if (sub == SUB_SMP) sh <= {sh[WORD_HALVES-2:0], rx};
        if (sub == SUB_LAST) begin
          sub <= '0;
          if (half == HALF_LAST) begin
            cap <= 1'b0; done <= 1'b1;
          end else half <= half + 1'b1;
        end else sub <= sub + 1'b1;
      end
    end
  end

  // R10: a result is only produced at the end of a capture
  p_done_after_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(cap));
endmodule

// File: rtl/lbt_seq.sv
module lbt_seq
  import lbt_pkg::*;
#(
  parameter int TO_CLKS = 416
) (
  input  logic clk,
  input  logic rst_n,
  input  logic test_en,
  input  logic wr,
  input  logic [3:0] wdata,
  input  logic dec_seen,
  input  logic dec_done,
  input  logic [3:0] dec_errs,
  output lbt_cfg_t cfg,
  output logic busy,
  output logic go,
  output logic pass,
  output logic fail,
  output logic [4:0] why
);
  localparam int CW = $clog2(TO_CLKS + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(TO_CLKS - 1);

  logic [CW-1:0] cnt;
  logic accept, tmo_hit;

  assign accept  = !busy && wr && wdata[0] && test_en;
  assign tmo_hit = busy && !dec_done && !dec_seen && (cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0; busy <= 1'b0; go <= 1'b0;
      pass <= 1'b0; fail <= 1'b0; why <= '0; cnt <= '0;
    end else begin
      go <= 1'b0;
      if (busy) begin
        if (dec_done) begin
          busy <= 1'b0;
          pass <= (dec_errs == 4'd0);
          fail <= (dec_errs != 4'd0);
          why  <= {1'b0, dec_errs};
        end else if (tmo_hit) begin
          busy <= 1'b0; fail <= 1'b1;
          why  <= 5'(1 << E_TMO);
        end else if (!dec_seen) begin
          cnt <= cnt + 1'b1;
        end
      end else if (wr) begin
        cfg <= wdata[3:1];
        if (accept) begin
          busy <= 1'b1; go <= 1'b1; cnt <= '0;
          pass <= 1'b0; fail <= 1'b0; why <= '0;
        end
      end
    end
  end

  // R6: a test begins only while the test input is high
  p_start_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(test_en));
  // R7: earlier results are gone once a new test begins
  p_clear_on_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!pass && !fail && why == 5'd0));
  // R8: the two verdicts exclude each other
  p_one_verdict_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fail));
  // R6: configuration holds still for the whole test
  p_cfg_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cfg));
endmodule

// File: rtl/lbt_top.sv
module lbt_top
  import lbt_pkg::*;
#(
  parameter int HALF_CLKS = 4,
  parameter int TIMEOUT_BITS = 32,
  parameter logic [15:0] TEST_WORD = 16'hA5C3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic test_en,
  input  logic reg_wr,
  input  logic [3:0] reg_wdata,
  output logic [3:0] ctl_o,
  output logic pass_o,
  output logic fail_o,
  output logic [4:0] fail_why_o,
  output logic bus_a_tx,
  output logic bus_a_txen,
  input  logic bus_a_rx,
  input  logic bus_a_rxact,
  output logic bus_b_tx,
  output logic bus_b_txen,
  input  logic bus_b_rx,
  input  logic bus_b_rxact
);
  localparam int TO_CLKS = (WORD_HALVES + 2 * TIMEOUT_BITS) * HALF_CLKS;

  lbt_cfg_t cfg;
  logic busy, go, dec_seen, dec_done;
  logic [3:0] dec_errs;
  logic enc_line, enc_act;
  logic drv_a, drv_b, rx_sel, rxact_sel;

  lbt_seq #(.TO_CLKS(TO_CLKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .test_en(test_en), .wr(reg_wr), .wdata(reg_wdata),
    .dec_seen(dec_seen), .dec_done(dec_done), .dec_errs(dec_errs),
    .cfg(cfg), .busy(busy), .go(go), .pass(pass_o), .fail(fail_o), .why(fail_why_o));

  lbt_enc #(.HALF_CLKS(HALF_CLKS), .WORD(TEST_WORD)) u_enc (
    .clk(clk), .rst_n(rst_n), .go(go), .cmd(cfg.sync_cmd), .line(enc_line), .act(enc_act));

  // bus routing
  assign drv_a = enc_act && cfg.analog && !cfg.bus_b;
  assign drv_b = enc_act && cfg.analog &&  cfg.bus_b;
  assign bus_a_txen = drv_a;
  assign bus_b_txen = drv_b;
  assign bus_a_tx = drv_a && enc_line;
  assign bus_b_tx = drv_b && enc_line;

  always_comb begin
    if (!cfg.analog) begin
      rx_sel = enc_line; rxact_sel = enc_act;
    end else if (cfg.bus_b) begin
      rx_sel = bus_b_rx; rxact_sel = bus_b_rxact;
    end else begin
      rx_sel = bus_a_rx; rxact_sel = bus_a_rxact;
    end
  end

  lbt_dec #(.HALF_CLKS(HALF_CLKS), .WORD(TEST_WORD)) u_dec (
    .clk(clk), .rst_n(rst_n), .arm(go), .cmd(cfg.sync_cmd), .rx(rx_sel), .rxact(rxact_sel),
    .seen(dec_seen), .done(dec_done), .errs(dec_errs));

  assign ctl_o = {cfg.analog, cfg.sync_cmd, cfg.bus_b, busy};

  // R1: internal loop keeps both buses silent
  p_quiet_digital_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_o[3] |-> (!bus_a_txen && !bus_b_txen && !bus_a_tx && !bus_b_tx));
  // R3: never both buses at once, and only the selected one
  p_one_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_a_txen && bus_b_txen) && !(bus_a_txen && ctl_o[1]) && !(bus_b_txen && !ctl_o[1]));
  // R2: the transmitter is only on while a test runs
  p_tx_in_test_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_a_txen || bus_b_txen) |-> ctl_o[0]);
endmodule

// File: tb/lbt_top_tb_top.sv
module lbt_top_tb_top;
  localparam int H = 4;
  localparam int NH = 40;
  localparam logic [15:0] PAT = 16'hA5C3;
  localparam int DONE_RX = NH * H + 2;
  localparam int DONE_TMO = (NH + 64) * H;

  logic clk = 0, rst_n = 0, test_en = 0, reg_wr = 0;
  logic [3:0] reg_wdata = '0;
  logic [3:0] ctl_o;
  logic pass_o, fail_o;
  logic [4:0] fail_why_o;
  logic bus_a_tx, bus_a_txen, bus_b_tx, bus_b_txen;
  logic bus_a_rx = 0, bus_a_rxact = 0, bus_b_rx = 0, bus_b_rxact = 0;

  always #5 clk = ~clk;

  lbt_top dut_i (
    .clk(clk), .rst_n(rst_n), .test_en(test_en), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .ctl_o(ctl_o), .pass_o(pass_o), .fail_o(fail_o), .fail_why_o(fail_why_o),
    .bus_a_tx(bus_a_tx), .bus_a_txen(bus_a_txen), .bus_a_rx(bus_a_rx), .bus_a_rxact(bus_a_rxact),
    .bus_b_tx(bus_b_tx), .bus_b_txen(bus_b_txen), .bus_b_rx(bus_b_rx), .bus_b_rxact(bus_b_rxact));

  int n_chk = 0, n_bad = 0, cyc = 0;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  // expected waveform, first half-bit at bit 39
  function automatic logic [NH-1:0] wave(input logic cmd);
    logic q[$];
    logic [NH-1:0] r;
    int ones = 0;
    for (int i = 0; i < 3; i++) q.push_back(cmd);
    for (int i = 0; i < 3; i++) q.push_back(!cmd);
    for (int i = 15; i >= 0; i--) begin
      q.push_back(PAT[i]); q.push_back(!PAT[i]);
      if (PAT[i]) ones++;
    end
    q.push_back(ones % 2 == 0); q.push_back(ones % 2 != 0);
    for (int i = 0; i < NH; i++) r[NH-1-i] = q[i];
    return r;
  endfunction

  // cause code {tmo, data, sync, parity, manch}
  function automatic logic [4:0] classify(input logic [NH-1:0] h, input logic cmd);
    logic [4:0] e = '0;
    logic [15:0] d = '0;
    int ones = 0;
    for (int i = 0; i < 6; i++)
      if (h[NH-1-i] !== ((i < 3) ? cmd : !cmd)) e[2] = 1;
    for (int c = 0; c < 17; c++) begin
      logic a, b;
      a = h[NH-7-2*c]; b = h[NH-8-2*c];
      if (a == b) e[0] = 1;
      if (a) ones++;
      if (c < 16) d[15-c] = a;
    end
    if (ones % 2 == 0) e[1] = 1;
    if (d != PAT) e[3] = 1;
    return e;
  endfunction

  // behavioural model
  logic m_busy = 0, m_pass = 0, m_fail = 0;
  logic [2:0] m_cfg = '0;
  logic [4:0] m_why = '0, m_exp = '0;
  int m_t = 0, m_done_at = 0;
  logic [NH-1:0] mask = '0, m_wave = '0;
  logic kill = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_pass = 0; m_fail = 0; m_cfg = '0; m_why = '0; m_t = 0;
    end else if (m_busy) begin
      m_t++;
      if (m_t == m_done_at) begin
        m_busy = 0; m_pass = (m_exp == 0); m_fail = (m_exp != 0); m_why = m_exp;
      end
    end else if (reg_wr) begin
      m_cfg = reg_wdata[3:1];
      if (reg_wdata[0] && test_en) begin
        m_busy = 1; m_t = 0; m_pass = 0; m_fail = 0; m_why = '0;
        m_wave = wave(m_cfg[1]);
        if (m_cfg[2] && kill) begin
          m_done_at = DONE_TMO; m_exp = 5'b10000;
        end else begin
          m_done_at = DONE_RX;
          m_exp = m_cfg[2] ? classify(m_wave ^ mask, m_cfg[1]) : 5'b0;
        end
      end
    end
  end

  // per-clock comparison and bus loopback
  always @(negedge clk) begin
    logic en, lvl, flip;
    int hf;
    cyc++;
    en = m_busy && m_t >= 1 && m_t <= NH * H;
    hf = en ? (m_t - 1) / H : 0;
    lvl = en && m_wave[NH-1-hf];
    flip = en && mask[NH-1-hf];
    if (rst_n) begin
      chk("R2/R3 bus A enable", {7'b0, bus_a_txen}, {7'b0, en && m_cfg[2] && !m_cfg[0]});
      chk("R3/R4/R5 bus A level", {7'b0, bus_a_tx}, {7'b0, lvl && m_cfg[2] && !m_cfg[0]});
      chk("R2/R3 bus B enable", {7'b0, bus_b_txen}, {7'b0, en && m_cfg[2] && m_cfg[0]});
      chk("R3/R4/R5 bus B level", {7'b0, bus_b_tx}, {7'b0, lvl && m_cfg[2] && m_cfg[0]});
      chk("R6/R11 control readback", {4'b0, ctl_o}, {4'b0, m_cfg, m_busy});
      chk("R8/R10 verdict", {6'b0, pass_o, fail_o}, {6'b0, m_pass, m_fail});
      chk("R8/R9 cause", {3'b0, fail_why_o}, {3'b0, m_why});
    end
    if (m_cfg[2]) begin
      bus_a_rx = bus_a_tx ^ flip;  bus_a_rxact = bus_a_txen && !kill;
      bus_b_rx = bus_b_tx ^ flip;  bus_b_rxact = bus_b_txen && !kill;
    end else begin
      bus_a_rx = cyc[0]; bus_a_rxact = 1; bus_b_rx = !cyc[0]; bus_b_rxact = cyc[1];
    end
  end

  task automatic wr4(input logic [3:0] d);
    @(negedge clk); reg_wr = 1; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic run(input string req, input logic [3:0] d, input logic [NH-1:0] m,
                     input logic k, input logic busy_wr, input logic [4:0] exp_why);
    mask = m; kill = k;
    wr4(d);
    for (int i = 0; i < 600 && m_busy; i++) begin
      @(negedge clk);
      if (busy_wr && i == 50) begin reg_wr = 1; reg_wdata = 4'b0011; end
      if (busy_wr && i == 51) begin reg_wr = 0; reg_wdata = '0; end
    end
    @(negedge clk);
    chk(req, {3'b0, fail_why_o}, {3'b0, exp_why});
    chk(req, {7'b0, pass_o}, {7'b0, exp_why == 0});
    repeat (3) @(negedge clk);
    mask = '0; kill = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 reset outputs", {ctl_o, pass_o, fail_o, bus_a_txen, bus_b_txen}, 8'h00);
    rst_n = 1;
    @(negedge clk);
    // start refused without the test input, config still taken
    wr4(4'b1011);
    repeat (4) @(negedge clk);
    chk("R6 start needs test_en", {7'b0, ctl_o[0]}, 8'h00);
    chk("R11 config follows idle write", {4'b0, ctl_o}, 8'h0A);
    test_en = 1;
    run("R1 digital loop ignores bus pins", 4'b0001, '1, 0, 0, 5'b00000);
    run("R2/R4 analog bus A command sync", 4'b1101, '0, 0, 0, 5'b00000);
    run("R3/R6 analog bus B data sync, write while busy", 4'b1011, '0, 0, 1, 5'b00000);
    run("R8 one sync half flipped", 4'b1101, 40'h10_0000_0000, 0, 0, 5'b00100);
    run("R8 all sync halves flipped (wrong type)", 4'b1101, 40'hFC_0000_0000, 0, 0, 5'b00100);
    run("R8 one data half flipped", 4'b1001, 40'h02_0000_0000, 0, 0, 5'b01011);
    run("R8 parity cell inverted", 4'b1011, 40'h00_0000_0003, 0, 0, 5'b00010);
    run("R8 one data cell inverted", 4'b1001, 40'h03_0000_0000, 0, 0, 5'b01010);
    run("R8 two data cells inverted", 4'b1101, 40'h00_0F00_0000, 0, 0, 5'b01000);
    run("R9 no receive activity", 4'b1001, '0, 1, 0, 5'b10000);
    run("R7 new start clears fail", 4'b1001, '0, 0, 0, 5'b00000);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule